// File: doc/BRIEF.md
# Grouped Wake-Up Event Controller

This block watches a bank of asynchronous wake-up inputs, arranged as groups of eight. Each input is resynchronised and can be gated off. It can then be qualified as an active-high or active-low level, or as a rising, falling or either-direction edge. A qualifying event latches a per-input pending flag. Software reads and configures each group through a small word-wide register port, and clears pending flags by writing ones.

A group is active when any of its pending flags has its interrupt enable set. Several groups can share one interrupt line. Each line has a programmable group mask, and the line is the OR of the active groups that its mask selects. A single wake request is the OR of every active group. It lets the surrounding system leave its low-power states.

Top module: `wake_irq_ctrl`

## Requirements
- R1: After reset every configuration register, pending flag and line mask reads 0, and `irq_o` and `wake_o` are low.
- R2: Address bit 6 = 0 selects group `addr[5:3]`, register `addr[2:0]`: 0 interrupt enable, 1 pending (read-only, writes ignored), 2 clear (write-only, reads 0), 3 mode, 4 polarity, 5 any-edge, 6 input enable. Address bit 6 = 1 selects the group mask of line `addr[1:0]`. Written configuration reads back unchanged.
- R3: With mode bit 1 (level), polarity 0 triggers on a high input and polarity 1 on a low input. The pending flag is set again on every cycle the active level lasts.
- R4: With mode bit 0 (edge) and any-edge 0, polarity 0 sets pending on a rising edge and polarity 1 on a falling edge.
- R5: With mode bit 0 and any-edge 1, both rising and falling edges set pending.
- R6: Writing a 1 to a clear bit clears that pending flag, and a 0 leaves it unchanged. A set event in the same cycle as a clear wins.
- R7: An input whose input-enable bit is 0 never sets pending. Enabling it while the input is high produces a rising-edge event.
- R8: Pending flags latch regardless of interrupt enable. A group's activity is the OR of pending AND interrupt enable.
- R9: `irq_o[k]` is the OR of the active groups whose bit is set in line k's mask. Mask 0x09 merges groups 0 and 3.
- R10: `wake_o` is high exactly when at least one group is active.
- R11: A change on `wk_in` reaches the pending flag on the third rising clock edge after it is applied (two synchroniser stages and one history stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wk_in | input | 64 | Raw wake inputs, bit 8*g+b is group g bit b |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq_o | output | 4 | Shared interrupt lines |
| wake_o | output | 1 | Global wake request |

## Verification
Every group is swept on one input through all five detection settings. Each setting sees a low-to-high step, a clear, a high-to-low step and another clear. The pending value after each step separates the level settings from the edge settings and shows which polarity and edge direction is in force. The clear taken while an active level persists shows that a set event overrides a clear. Directed patterns cover the remaining behaviour. One pulse is timed edge by edge to pin the latency. Events are placed in masked and unmasked groups to tell the line merging apart from the wake OR, and toggles on a disabled input show the gating and the spurious event that follows enabling it.

// File: rtl/wk_pkg.sv
package wk_pkg;
    localparam int WK_GW = 8;

    typedef enum logic [2:0] {
        REG_IEN  = 3'd0,
        REG_PEND = 3'd1,
        REG_CLR  = 3'd2,
        REG_MODE = 3'd3,
        REG_POL  = 3'd4,
        REG_ANY  = 3'd5,
        REG_INEN = 3'd6,
        REG_NONE = 3'd7
    } wk_reg_e;

    typedef struct packed {
        logic [WK_GW-1:0] ien;
        logic [WK_GW-1:0] mode;
        logic [WK_GW-1:0] pol;
        logic [WK_GW-1:0] any;
        logic [WK_GW-1:0] inen;
    } wk_cfg_t;
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/wk_group_detect.sv
module wk_group_detect
    import wk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WK_GW-1:0] sync_in,
    input  wk_cfg_t          cfg,
    input  logic [WK_GW-1:0] clr_mask,
    output logic [WK_GW-1:0] pend,
    output logic             act
);
    logic [WK_GW-1:0] gated, prev, rise, fall, lvl_hit, edg_hit, set_vec;

    always_comb begin
        gated   = sync_in & cfg.inen;
        rise    = gated & ~prev;
        fall    = ~gated & prev;
        lvl_hit = gated ^ cfg.pol;
        edg_hit = (cfg.any & (rise | fall)) |
                  (~cfg.any & ((rise & ~cfg.pol) | (fall & cfg.pol)));
        set_vec = cfg.inen & ((cfg.mode & lvl_hit) | (~cfg.mode & edg_hit));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= '0;
            pend <= '0;
        end else begin
            prev <= gated;
            pend <= (pend & ~clr_mask) | set_vec;
        end
    end

    assign act = |(pend & cfg.ien);

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask == '0) |=> ((pend & $past(pend)) == $past(pend))); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec))); // R6
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.inen == '0 && clr_mask == '0) |=> (pend == $past(pend))); // R7
endmodule

// File: rtl/wk_line_merge.sv
module wk_line_merge #(
    parameter int NUM_GROUPS = 8,
    parameter int NUM_LINES  = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_GROUPS-1:0]           grp_act,
    input  logic [NUM_LINES*NUM_GROUPS-1:0] line_mask,
    output logic [NUM_LINES-1:0]            irq,
    output logic                            wake
);
    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        assign irq[k] = |(grp_act & line_mask[k*NUM_GROUPS +: NUM_GROUPS]);
    end

    assign wake = |grp_act;

    AST_LINE_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != '0) |-> wake); // R10
endmodule

// File: rtl/wake_irq_ctrl.sv
module wake_irq_ctrl
    import wk_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int NUM_LINES  = 4,
    localparam int GRP_AW  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int LINE_AW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int ADDR_W  = GRP_AW + 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GROUPS*WK_GW-1:0] wk_in,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [WK_GW-1:0]            bus_wdata,
    output logic [WK_GW-1:0]            bus_rdata,
    output logic [NUM_LINES-1:0]        irq_o,
    output logic                        wake_o
);
    logic                            is_line;
    logic [GRP_AW-1:0]               a_grp;
    wk_reg_e                         a_reg;
    logic [LINE_AW-1:0]              a_line;
    wk_cfg_t                         cfg_q     [NUM_GROUPS];
    logic [NUM_GROUPS-1:0]           lmask_q   [NUM_LINES];
    logic [WK_GW-1:0]                clr_v     [NUM_GROUPS];
    logic [WK_GW-1:0]                pend_v    [NUM_GROUPS];
    logic [NUM_GROUPS-1:0]           grp_act;
    logic [NUM_LINES*NUM_GROUPS-1:0] lmask_flat;
    logic [NUM_GROUPS*WK_GW-1:0]     sync_in;

    assign is_line = bus_addr[ADDR_W-1];
    assign a_grp   = bus_addr[GRP_AW+2:3];
    assign a_reg   = wk_reg_e'(bus_addr[2:0]);
    assign a_line  = bus_addr[LINE_AW-1:0];

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < NUM_GROUPS; g++) cfg_q[g] <= '0;
            for (int k = 0; k < NUM_LINES; k++) lmask_q[k] <= '0;
        end else if (bus_we) begin
            if (is_line) begin
                for (int k = 0; k < NUM_LINES; k++)
                    if (a_line == LINE_AW'(k)) lmask_q[k] <= bus_wdata[NUM_GROUPS-1:0];
            end else begin
                for (int g = 0; g < NUM_GROUPS; g++) begin
                    if (a_grp == GRP_AW'(g)) begin
                        case (a_reg)
                            REG_IEN:  cfg_q[g].ien  <= bus_wdata;
                            REG_MODE: cfg_q[g].mode <= bus_wdata;
                            REG_POL:  cfg_q[g].pol  <= bus_wdata;
                            REG_ANY:  cfg_q[g].any  <= bus_wdata;
                            REG_INEN: cfg_q[g].inen <= bus_wdata;
                            default:  ;
                        endcase
                    end
                end
            end
        end
    end

    // write-one-to-clear strobes
    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++)
            clr_v[g] = (bus_we && !is_line && a_grp == GRP_AW'(g) && a_reg == REG_CLR)
                       ? bus_wdata : '0;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (is_line) begin
            for (int k = 0; k < NUM_LINES; k++)
                if (a_line == LINE_AW'(k)) bus_rdata = WK_GW'(lmask_q[k]);
        end else begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (a_grp == GRP_AW'(g)) begin
                    case (a_reg)
                        REG_IEN:  bus_rdata = cfg_q[g].ien;
                        REG_PEND: bus_rdata = pend_v[g];
                        REG_MODE: bus_rdata = cfg_q[g].mode;
                        REG_POL:  bus_rdata = cfg_q[g].pol;
                        REG_ANY:  bus_rdata = cfg_q[g].any;
                        REG_INEN: bus_rdata = cfg_q[g].inen;
                        default:  bus_rdata = '0;
                    endcase
                end
            end
        end
    end

    wk_sync #(.W(NUM_GROUPS*WK_GW)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(wk_in), .q(sync_in)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        wk_group_detect u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_in  (sync_in[g*WK_GW +: WK_GW]),
            .cfg      (cfg_q[g]),
            .clr_mask (clr_v[g]),
            .pend     (pend_v[g]),
            .act      (grp_act[g])
        );
    end

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_lm
        assign lmask_flat[k*NUM_GROUPS +: NUM_GROUPS] = lmask_q[k];
    end

    wk_line_merge #(.NUM_GROUPS(NUM_GROUPS), .NUM_LINES(NUM_LINES)) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .grp_act   (grp_act),
        .line_mask (lmask_flat),
        .irq       (irq_o),
        .wake      (wake_o)
    );

    AST_WAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_o) |-> (irq_o == '0)); // R9
endmodule

// File: tb/sim_wake_irq_ctrl.sv
module sim_wake_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] wk_in = '0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [3:0]  irq_o;
    logic        wake_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam int IEN = 0, PEND = 1, CLR = 2, MODE = 3, POL = 4, ANY = 5, INEN = 6;

    always #2 clk = ~clk;

    wake_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wk_in(wk_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    function automatic logic [6:0] ga(input int g, input int r);
        return {1'b0, g[2:0], r[2:0]};
    endfunction

    function automatic logic [6:0] la(input int k);
        return {1'b1, 4'b0000, k[1:0]};
    endfunction

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_rd(input string tag, input logic [6:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, {24'h0, v}, {24'h0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL WDOG actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk_rd("R1 pend g0", ga(0, PEND), 8'h00);
        chk_rd("R1 ien g7", ga(7, IEN), 8'h00);
        chk_rd("R1 inen g5", ga(5, INEN), 8'h00);
        chk_rd("R1 mask l3", la(3), 8'h00);
        chk("R1 irq", {28'h0, irq_o}, 32'h0);
        chk("R1 wake", {31'h0, wake_o}, 32'h0);

        // R2 register map
        wr(ga(2, IEN), 8'hA5);
        wr(ga(5, MODE), 8'h3C);
        wr(la(3), 8'h81);
        wr(ga(1, PEND), 8'hFF);
        chk_rd("R2 ien g2", ga(2, IEN), 8'hA5);
        chk_rd("R2 mode g5", ga(5, MODE), 8'h3C);
        chk_rd("R2 mask l3", la(3), 8'h81);
        chk_rd("R2 pend ro", ga(1, PEND), 8'h00);
        chk_rd("R2 clr reads 0", ga(1, CLR), 8'h00);
        wr(ga(2, IEN), 8'h00);
        wr(ga(5, MODE), 8'h00);
        wr(la(3), 8'h00);

        // R11 latency, rising edge on group 0 bit 0
        wr(ga(0, INEN), 8'h01);
        idle(3);
        wk_in[0] = 1'b1;
        idle(2);
        chk_rd("R11 after 2 edges", ga(0, PEND), 8'h00);
        idle(1);
        chk_rd("R11 after 3 edges", ga(0, PEND), 8'h01);

        // R8 latch with interrupt disabled
        chk("R8 irq off", {28'h0, irq_o}, 32'h0);
        chk("R8 wake off", {31'h0, wake_o}, 32'h0);
        wr(ga(0, IEN), 8'h01);
        wr(la(0), 8'h09);
        chk("R8 irq on", {28'h0, irq_o}, 32'h1);
        chk("R10 wake on", {31'h0, wake_o}, 32'h1);

        // R9 line merging
        wr(ga(0, CLR), 8'hFF);
        chk("R9 cleared", {28'h0, irq_o}, 32'h0);
        wr(la(1), 8'h02);
        wr(ga(3, INEN), 8'h01); wr(ga(3, IEN), 8'h01);
        wk_in[24] = 1'b1; idle(4);
        chk("R9 g3 on line0", {28'h0, irq_o}, 32'h1);
        wr(ga(1, INEN), 8'h01); wr(ga(1, IEN), 8'h01);
        wk_in[8] = 1'b1; idle(4);
        chk("R9 g1 on line1", {28'h0, irq_o}, 32'h3);
        wr(ga(3, CLR), 8'hFF);
        chk("R9 g3 cleared", {28'h0, irq_o}, 32'h2);
        wr(ga(2, INEN), 8'h01); wr(ga(2, IEN), 8'h01);
        wk_in[16] = 1'b1; idle(4);
        chk("R9 g2 unmapped", {28'h0, irq_o}, 32'h2);
        wr(ga(1, CLR), 8'hFF);
        chk("R10 wake from g2", {31'h0, wake_o}, 32'h1);
        chk("R9 no line", {28'h0, irq_o}, 32'h0);
        wr(ga(2, CLR), 8'hFF);
        chk("R10 wake idle", {31'h0, wake_o}, 32'h0);

        // R6 selective clear
        wr(ga(4, ANY), 8'h03); wr(ga(4, INEN), 8'h03);
        wk_in[33:32] = 2'b11; idle(4);
        chk_rd("R5 two bits", ga(4, PEND), 8'h03);
        wr(ga(4, CLR), 8'h01);
        chk_rd("R6 clear one", ga(4, PEND), 8'h02);
        wr(ga(4, CLR), 8'h00);
        chk_rd("R6 clear none", ga(4, PEND), 8'h02);
        wr(ga(4, CLR), 8'hFF);
        chk_rd("R6 clear all", ga(4, PEND), 8'h00);

        // R7 input enable gating
        wr(ga(6, ANY), 8'h04);
        wk_in[50] = 1'b1; idle(4);
        wk_in[50] = 1'b0; idle(4);
        chk_rd("R7 disabled toggle", ga(6, PEND), 8'h00);
        wk_in[50] = 1'b1; idle(4);
        chk_rd("R7 disabled high", ga(6, PEND), 8'h00);
        wr(ga(6, INEN), 8'h04); idle(4);
        chk_rd("R7 spurious on enable", ga(6, PEND), 8'h04);

        // sweep: every group, five detection settings
        for (int g = 0; g < 8; g++) begin
            for (int c = 0; c < 5; c++) begin
                logic L, P, A;
                logic [7:0] bm;
                string t;
                L  = (c < 2);
                P  = (c == 1) || (c == 3);
                A  = (c == 4);
                bm = 8'h01 << g;
                t  = L ? "R3" : (A ? "R5" : "R4");
                wk_in[g*8 + g] = 1'b0;
                wr(ga(g, INEN), 8'h00);
                wr(ga(g, MODE), L ? bm : 8'h00);
                wr(ga(g, POL), P ? bm : 8'h00);
                wr(ga(g, ANY), A ? bm : 8'h00);
                wr(ga(g, INEN), bm);
                idle(4);
                wr(ga(g, CLR), 8'hFF);
                chk_rd({t, " idle low"}, ga(g, PEND), (L & P) ? bm : 8'h00);
                wk_in[g*8 + g] = 1'b1; idle(5);
                chk_rd({t, " step up"}, ga(g, PEND), (L | A | ~P) ? bm : 8'h00);
                wr(ga(g, CLR), 8'hFF);
                chk_rd({t, " R6 clear high"}, ga(g, PEND), (L & ~P) ? bm : 8'h00);
                wk_in[g*8 + g] = 1'b0; idle(5);
                chk_rd({t, " step down"}, ga(g, PEND), (L | A | P) ? bm : 8'h00);
                wr(ga(g, CLR), 8'hFF);
                chk_rd({t, " R6 clear low"}, ga(g, PEND), (L & P) ? bm : 8'h00);
            end
            wr(ga(g, INEN), 8'h00);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule